// File: doc/BRIEF.md
# Per-Pin Input Debounce Filter

This block filters the synchronized input levels of four 8-bit pin groups before they reach the input-read and interrupt logic. Each pin has its own enable. When the enable is clear, the pin passes straight through. When it is set, the pin's filtered level changes only after the raw level has held a new value for a programmed number of consecutive millisecond ticks. The tick is a single-cycle strobe supplied from outside the block.

All eight pins of a group share one 8-bit tick count, which ranges from 0 to 255. Each pin still keeps its own stability counter, so a noisy pin does not disturb its neighbours. Software reaches the block through a small register port. One register per group holds the count. A second register per group holds the eight enables. It is written in the select/value form, so single pins can change without a read-modify-write.

Top module: `pin_debounce`

## Requirements
- R1: After reset, every enable and every count reads as zero, and every filtered output equals its raw input.
- R2: A write with regAddr[2]=1 updates the enables of group regAddr[1:0]. Pin i takes regWdata[i] only where regWdata[8+i] is 1; all other enables of that group keep their value.
- R3: A read returns the selected group's enables (regAddr[2]=1) or its count (regAddr[2]=0) in bits 7:0, with bits 15:8 always zero.
- R4: A pin whose enable is 0 drives its raw input to its filtered output in the same cycle, whatever its group's count.
- R5: For an enabled pin with a nonzero count N, the filtered output takes the raw value on the clock edge that samples the Nth consecutive tick during which the raw level differed from the output. Without ticks, the output does not change.
- R6: If the raw level of a filtering pin returns to the filtered value, the pin's tick count starts again from zero.
- R7: An enabled pin whose group count is 0 passes its raw input through unchanged.
- R8: When filtering turns on for a pin, its filtered output starts from the raw level sampled on that edge, with no delay.
- R9: A count write with regAddr[2]=0 stores regWdata[7:0] and ignores regWdata[15:8]. One count serves all eight pins of its group, and the groups time out independently.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| msTick | input | 1 | One-cycle millisecond strobe |
| rawIn | input | 32 | Synchronized pad levels, group g at bits 8g+7:8g |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 3 | Bit 2: enable (1) or count (0); bits 1:0: group |
| regWdata | input | 16 | Write data |
| regRdata | output | 16 | Read data for regAddr |
| filtOut | output | 32 | Filtered pin levels |

## Verification
The assertions assume that rawIn is already synchronous to clk. They also assume that msTick is a strobe sampled only on rising edges, so a level that is held stays consistent with the one-cycle tick model. The stimulus changes rawIn, msTick and the register inputs only on falling edges. It raises msTick for exactly one cycle at a time, and it keeps register writes apart from tick cycles so that each count and enable is settled before filtering is judged.

// File: rtl/dbnc_pkg.sv
package dbnc_pkg;
  localparam int NUM_PORTS = 4;
  localparam int PORT_W    = 8;
  localparam int CNT_W     = 8;
  localparam int TOTAL     = NUM_PORTS * PORT_W;

  // strobes from the control side to the filter datapath
  typedef struct packed {
    logic [TOTAL-1:0] filtOn;  // pin is enabled and its group count is nonzero
    logic             tick;    // millisecond strobe
  } dbStrobes_t;
endpackage

// File: rtl/dbnc_ctrl.sv
module dbnc_ctrl
  import dbnc_pkg::*;
#(
  parameter int NPORT  = NUM_PORTS,
  parameter int PW     = PORT_W,
  parameter int CW     = CNT_W,
  localparam int PSEL_W = (NPORT > 1) ? $clog2(NPORT) : 1,
  localparam int ADDR_W = PSEL_W + 1,
  localparam int DATA_W = 2 * PW,
  localparam int NPIN   = NPORT * PW
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              msTick,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic [NPIN-1:0]   pinEn,
  output logic [NPORT*CW-1:0] portCount,
  output dbStrobes_t        strb
);
  logic [PW-1:0] enReg  [NPORT];
  logic [CW-1:0] cntReg [NPORT];
  logic [PSEL_W-1:0] portSel;
  logic isEnable;
  logic [PW-1:0] selMask, selVal;

  assign portSel  = regAddr[PSEL_W-1:0];
  assign isEnable = regAddr[PSEL_W];
  assign selMask  = regWdata[DATA_W-1:PW];
  assign selVal   = regWdata[PW-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int p = 0; p < NPORT; p++) begin
        enReg[p]  <= '0;
        cntReg[p] <= '0;
      end
    end else if (regWr && (int'(portSel) < NPORT)) begin
      if (isEnable)
        enReg[portSel] <= (enReg[portSel] & ~selMask) | (selVal & selMask);
      else
        cntReg[portSel] <= regWdata[CW-1:0];
    end
  end

  always_comb begin
    regRdata = '0;
    if (int'(portSel) < NPORT) begin
      if (isEnable) regRdata[PW-1:0] = enReg[portSel];
      else          regRdata[CW-1:0] = cntReg[portSel];
    end
  end

  generate
    for (genvar p = 0; p < NPORT; p++) begin : g_port
      assign pinEn[p*PW +: PW]     = enReg[p];
      assign portCount[p*CW +: CW] = cntReg[p];
      assign strb.filtOn[p*PW +: PW] = enReg[p] & {PW{|cntReg[p]}};
    end
  endgenerate

  assign strb.tick = msTick;
endmodule

// File: rtl/dbnc_datapath.sv
module dbnc_datapath
  import dbnc_pkg::*;
#(
  parameter int NPORT = NUM_PORTS,
  parameter int PW    = PORT_W,
  parameter int CW    = CNT_W,
  localparam int NPIN = NPORT * PW
) (
  input  logic                clk,
  input  logic                rstN,
  input  dbStrobes_t          strb,
  input  logic [NPORT*CW-1:0] portCount,
  input  logic [NPIN-1:0]     rawIn,
  output logic [NPIN-1:0]     filtOut
);
  generate
    for (genvar i = 0; i < NPIN; i++) begin : g_pin
      localparam int GRP = i / PW;
      logic          state;
      logic [CW-1:0] stableCnt;
      logic [CW:0]   nextCnt;
      logic [CW-1:0] limit;

      assign limit   = portCount[GRP*CW +: CW];
      assign nextCnt = {1'b0, stableCnt} + 1'b1;

      always_ff @(posedge clk) begin
        if (!rstN) begin
          state     <= 1'b0;
          stableCnt <= '0;
        end else if (!strb.filtOn[i]) begin
          state     <= rawIn[i];   // track raw so enabling starts from it
          stableCnt <= '0;
        end else if (rawIn[i] == state) begin
          stableCnt <= '0;
        end else if (strb.tick) begin
          if (nextCnt >= {1'b0, limit}) begin
            state     <= rawIn[i];
            stableCnt <= '0;
          end else begin
            stableCnt <= nextCnt[CW-1:0];
          end
        end
      end

      assign filtOut[i] = strb.filtOn[i] ? state : rawIn[i];
    end
  endgenerate
endmodule

// File: rtl/pin_debounce.sv
module pin_debounce
  import dbnc_pkg::*;
#(
  parameter int NPORT  = NUM_PORTS,
  parameter int PW     = PORT_W,
  parameter int CW     = CNT_W,
  localparam int PSEL_W = (NPORT > 1) ? $clog2(NPORT) : 1,
  localparam int ADDR_W = PSEL_W + 1,
  localparam int DATA_W = 2 * PW,
  localparam int NPIN   = NPORT * PW
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              msTick,
  input  logic [NPIN-1:0]   rawIn,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic [NPIN-1:0]   filtOut
);
  dbStrobes_t          strb;
  logic [NPIN-1:0]     pinEn;
  logic [NPORT*CW-1:0] portCount;

  dbnc_ctrl #(.NPORT(NPORT), .PW(PW), .CW(CW)) u_ctrl (
    .clk(clk), .rstN(rstN), .msTick(msTick), .regWr(regWr),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .pinEn(pinEn), .portCount(portCount), .strb(strb)
  );

  dbnc_datapath #(.NPORT(NPORT), .PW(PW), .CW(CW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .portCount(portCount),
    .rawIn(rawIn), .filtOut(filtOut)
  );
endmodule

// File: rtl/dbnc_checker.sv
module dbnc_checker #(
  parameter int NPORT = 4,
  parameter int PW    = 8,
  parameter int CW    = 8,
  localparam int NPIN = NPORT * PW
) (
  input logic                clk,
  input logic                rstN,
  input logic                msTick,
  input logic [NPIN-1:0]     rawIn,
  input logic [NPIN-1:0]     filtOut,
  input logic [PW-1:0]       rdHigh,
  input logic [NPIN-1:0]     pinEn,
  input logic [NPORT*CW-1:0] portCount
);
  logic [NPIN-1:0] act;
  generate
    for (genvar p = 0; p < NPORT; p++) begin : g_act
      assign act[p*PW +: PW] = pinEn[p*PW +: PW] & {PW{|portCount[p*CW +: CW]}};
    end
  endgenerate

  assert_bypass_R4: assert property (@(posedge clk) disable iff (!rstN)
    ((filtOut ^ rawIn) & ~act) == '0);

  assert_no_tick_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !msTick |=> ((filtOut ^ $past(filtOut)) & act & $past(act)) == '0);

  assert_change_to_raw_R5: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((filtOut ^ $past(filtOut)) & act & $past(act) & (filtOut ^ $past(rawIn))) == '0);

  assert_start_from_raw_R8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (act & ~$past(act) & (filtOut ^ $past(rawIn))) == '0);

  assert_read_upper_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    rdHigh == '0);
endmodule

bind pin_debounce dbnc_checker #(.NPORT(NPORT), .PW(PW), .CW(CW)) u_chk (
  .clk(clk), .rstN(rstN), .msTick(msTick), .rawIn(rawIn), .filtOut(filtOut),
  .rdHigh(regRdata[2*PW-1:PW]), .pinEn(pinEn), .portCount(portCount)
);

// File: tb/pin_debounce_tb.sv
`timescale 1ns/1ps
module pin_debounce_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        msTick = 1'b0;
  logic [31:0] rawIn = 32'h0;
  logic        regWr = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [15:0] regWdata = 16'h0;
  logic [15:0] regRdata;
  logic [31:0] filtOut;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  pin_debounce u_dut (
    .clk(clk), .rstN(rstN), .msTick(msTick), .rawIn(rawIn), .regWr(regWr),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata), .filtOut(filtOut)
  );

  // {count, new raw, ticks, expected} for group 0
  localparam logic [31:0] VEC [8] = '{
    32'h03_A5_02_00, 32'h03_A5_03_A5, 32'h01_0F_01_0F, 32'h00_3C_00_3C,
    32'h05_FF_04_00, 32'h05_FF_05_FF, 32'hFF_81_FE_00, 32'hFF_81_FF_81
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk); regWr = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); regAddr = a; #2; d = regRdata;
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      @(negedge clk); msTick = 1'b1;
      @(negedge clk); msTick = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    rawIn = 32'hDEADBEEF;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #2;
    chk("R1 reset bypass", filtOut, 32'hDEADBEEF);
    regRead(3'd2, rd); chk("R1 count zero", {16'h0, rd}, 32'h0);
    regRead(3'd7, rd); chk("R1 enable zero", {16'h0, rd}, 32'h0);

    // masked enable writes on group 1
    regWrite(3'd5, 16'h0F05);
    regRead(3'd5, rd); chk("R2 masked low nibble", {16'h0, rd}, 32'h0005);
    regWrite(3'd5, 16'hF0F0);
    regRead(3'd5, rd); chk("R2 R3 masked high nibble", {16'h0, rd}, 32'h00F5);
    regWrite(3'd5, 16'h00FF);
    regRead(3'd5, rd); chk("R2 empty select keeps", {16'h0, rd}, 32'h00F5);

    // count write ignores upper byte; group 1 raw is 0xBE
    regWrite(3'd1, 16'hAB07);
    regRead(3'd1, rd); chk("R9 R3 count readback", {16'h0, rd}, 32'h0007);
    @(negedge clk); rawIn[15:8] = 8'h00; #2;
    chk("R4 disabled pins follow", {24'h0, filtOut[15:8]}, 32'hB4);
    ticks(6);
    chk("R5 before count", {24'h0, filtOut[15:8]}, 32'hB4);
    ticks(1);
    chk("R5 at count", {24'h0, filtOut[15:8]}, 32'h00);
    @(negedge clk); rawIn[15:8] = 8'hFF;
    repeat (50) @(negedge clk); #2;
    chk("R5 no tick holds", {24'h0, filtOut[15:8]}, 32'h0A);

    // restart on glitch, group 2 raw 0xAD
    regWrite(3'd2, 16'h0004);
    regWrite(3'd6, 16'hFFFF);
    @(negedge clk); rawIn[23:16] = 8'h52;
    ticks(3);
    chk("R6 partial", {24'h0, filtOut[23:16]}, 32'hAD);
    @(negedge clk); rawIn[23:16] = 8'hAD;
    ticks(1);
    @(negedge clk); rawIn[23:16] = 8'h52;
    ticks(3);
    chk("R6 restarted", {24'h0, filtOut[23:16]}, 32'hAD);
    ticks(1);
    chk("R6 full after restart", {24'h0, filtOut[23:16]}, 32'h52);

    // independent groups: group 3 count 2, group 2 count 4
    regWrite(3'd3, 16'h0002);
    regWrite(3'd7, 16'hFFFF);
    @(negedge clk); rawIn[31:24] = 8'h21; rawIn[23:16] = 8'hAD;
    ticks(2);
    chk("R9 group3 short count", {16'h0, filtOut[31:16]}, 32'h2152);
    ticks(2);
    chk("R9 group2 long count", {16'h0, filtOut[31:16]}, 32'h21AD);

    // enable starts from raw, group 0
    regWrite(3'd0, 16'h0009);
    @(negedge clk); rawIn[7:0] = 8'h3C;
    regWrite(3'd4, 16'hFFFF);
    #2 chk("R8 start from raw", {24'h0, filtOut[7:0]}, 32'h3C);
    ticks(9);
    chk("R8 steady", {24'h0, filtOut[7:0]}, 32'h3C);

    // vector table on group 0
    for (int k = 0; k < 8; k++) begin
      regWrite(3'd4, 16'hFF00);
      @(negedge clk); rawIn[7:0] = 8'h00;
      regWrite(3'd0, {8'h00, VEC[k][31:24]});
      regWrite(3'd4, 16'hFFFF);
      @(negedge clk); rawIn[7:0] = VEC[k][23:16];
      ticks(int'(VEC[k][15:8]));
      #2;
      chk((VEC[k][31:24] == 8'h0) ? "R7 zero count passes" : "R5 vector",
          {24'h0, filtOut[7:0]}, {24'h0, VEC[k][7:0]});
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule